// File: doc/BRIEF.md
# Programmable-Modulus Up/Down Loop Filter Counter

This block is the sequential filter stage of an all-digital phase-locked loop. It runs on its own fast counter clock. On each enabled edge it steps its count by one, up or down, as a one-bit phase-error input directs. The count lives in the range 0 to K. An upward wrap past K gives a single-cycle carry pulse. A downward wrap past zero gives a single-cycle borrow pulse. A later pulse-editing stage uses these pulses to add or drop output edges. A long run of one phase-error polarity yields a steady stream of pulses, while a balanced error signal makes the count wander and rarely wrap.

A four-bit select code chooses the modulus K as a power of two. The choice is sampled only at reset and at each wrap, so a count already under way always finishes against the modulus it began with. Every pin is plain control or status. No data stream passes through the block, so it has no valid/ready handshake and applies no back-pressure.

Top module: `kmod_loop_counter`

## Requirements
- R1: A synchronous reset, high on a clock edge, clears both pulse outputs, loads the active modulus from the select code, and sets the count to half of it. With code 0 and counting up, the first carry then shows in the cycle after the 5th enabled edge.
- R2: When `dir_i` is 0 and `en_i` is 1, the count rises by one per edge. An edge taken with the count equal to K sets the count to 0 and raises `carry_o` in the next cycle. Steady upward counting therefore carries once every K+1 edges.
- R3: When `dir_i` is 1 and `en_i` is 1, the count falls by one per edge. An edge taken with the count at 0 sets the count to K and raises `borrow_o` in the next cycle.
- R4: The select code n gives K = 2^(n+3), with the exponent capped at 15. Codes 12 to 15 all give K = 32768, and code 15 after reset carries on the 16385th upward edge.
- R5: With `en_i` low, the count holds and neither pulse output is raised in the following cycle. Counting later resumes from the held value.
- R6: Each pulse lasts exactly one clock cycle, and `carry_o` and `borrow_o` are never high together.
- R7: A new select code is adopted only at the next wrap in either direction. A wrap reloads the modulus from the code present on that edge.
- R8: The count never exceeds the active K. After a borrow reload, a single upward edge produces a carry.
- R9: The direction may reverse on any edge, and counting continues from the current value in the new direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Counter clock |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Count enable |
| dir_i | input | 1 | Phase-error direction: 0 counts up, 1 counts down |
| ksel_i | input | 4 | Modulus select code |
| carry_o | output | 1 | One-cycle pulse on an upward wrap |
| borrow_o | output | 1 | One-cycle pulse on a downward wrap |

## Verification
The bench targets four corner cases.

- **Starting point after reset.** The bench times the first carry after reset. A counter that started at zero or at K instead of K/2 would be off by several edges.
- **Select change in mid-count.** The bench changes the select code partway through a count. A design that took the new modulus at once would wrap early or late, and the bench would see that.
- **Largest modulus.** The clamped top code must give 32768. Code 15 run to its first carry would expose a design that overflowed its shift or dropped the cap.
- **Reload and reversals.** The bench checks that a borrow reload lands exactly on K, so one upward edge carries at once. Random runs with reversals and enable gaps compare every cycle against a model, which catches a hold that leaks a pulse or a reversal that skips a step.

// File: rtl/kmod_pkg.sv
package kmod_pkg;
  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } dir_e;
endpackage

// File: rtl/kmod_decode.sv
// Select code to modulus: K = 2^(code + BASE_EXP), exponent capped at CNT_W-1 (R4).
module kmod_decode #(
  parameter int SEL_W    = 4,
  parameter int CNT_W    = 16,
  parameter int BASE_EXP = 3
) (
  input  logic [SEL_W-1:0] sel_i,
  output logic [CNT_W-1:0] k_o
);
  localparam int NCODE = 1 << SEL_W;
  localparam int MAXE  = CNT_W - 1;

  logic [CNT_W-1:0] k_tbl [NCODE];

  for (genvar g = 0; g < NCODE; g++) begin : g_code
    localparam int EXP = ((g + BASE_EXP) > MAXE) ? MAXE : (g + BASE_EXP);
    assign k_tbl[g] = CNT_W'(1) << EXP;
  end

  assign k_o = k_tbl[sel_i];
endmodule

// File: rtl/kmod_step.sv
// Next-state logic for one counter-clock edge.
module kmod_step #(
  parameter int CNT_W = 16
) (
  input  logic             en_i,
  input  logic             dir_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] k_cur_i,
  input  logic [CNT_W-1:0] k_sel_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] k_o,
  output logic             carry_o,
  output logic             borrow_o
);
  import kmod_pkg::*;

  always_comb begin
    cnt_o    = cnt_i;
    k_o      = k_cur_i;
    carry_o  = 1'b0;
    borrow_o = 1'b0;
    if (en_i) begin
      if (dir_i == DIR_UP) begin
        if (cnt_i == k_cur_i) begin
          cnt_o   = '0;
          k_o     = k_sel_i;
          carry_o = 1'b1;
        end else begin
          cnt_o = cnt_i + CNT_W'(1);
        end
      end else begin
        if (cnt_i == '0) begin
          cnt_o    = k_sel_i;
          k_o      = k_sel_i;
          borrow_o = 1'b1;
        end else begin
          cnt_o = cnt_i - CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/kmod_loop_counter.sv
module kmod_loop_counter #(
  parameter int SEL_W    = 4,
  parameter int CNT_W    = 16,
  parameter int BASE_EXP = 3
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             en_i,
  input  logic             dir_i,
  input  logic [SEL_W-1:0] ksel_i,
  output logic             carry_o,
  output logic             borrow_o
);
  logic [CNT_W-1:0] cnt_q, k_q;
  logic [CNT_W-1:0] k_sel, cnt_d, k_d;
  logic             carry_d, borrow_d;
  logic             live_q;

  kmod_decode #(
    .SEL_W(SEL_W), .CNT_W(CNT_W), .BASE_EXP(BASE_EXP)
  ) u_decode (
    .sel_i (ksel_i),
    .k_o   (k_sel)
  );

  kmod_step #(
    .CNT_W(CNT_W)
  ) u_step (
    .en_i     (en_i),
    .dir_i    (dir_i),
    .cnt_i    (cnt_q),
    .k_cur_i  (k_q),
    .k_sel_i  (k_sel),
    .cnt_o    (cnt_d),
    .k_o      (k_d),
    .carry_o  (carry_d),
    .borrow_o (borrow_d)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      k_q      <= k_sel;
      cnt_q    <= k_sel >> 1;
      carry_o  <= 1'b0;
      borrow_o <= 1'b0;
      live_q   <= 1'b0;
    end else begin
      k_q      <= k_d;
      cnt_q    <= cnt_d;
      carry_o  <= carry_d;
      borrow_o <= borrow_d;
      live_q   <= 1'b1;
    end
  end

  // R6: never both pulses at once
  a_r6_no_both: assert property (@(posedge clk_i) disable iff (rst_i)
    !(carry_o && borrow_o));
  // R6: pulses are single-cycle
  a_r6_carry_single: assert property (@(posedge clk_i) disable iff (rst_i)
    carry_o |=> !carry_o);
  a_r6_borrow_single: assert property (@(posedge clk_i) disable iff (rst_i)
    borrow_o |=> !borrow_o);
  // R5: disabled edge holds count and yields no pulse
  a_r5_hold: assert property (@(posedge clk_i) disable iff (rst_i || !live_q)
    !en_i |=> ($stable(cnt_q) && !carry_o && !borrow_o));
  // R2: a carry leaves the count at zero
  a_r2_carry_zero: assert property (@(posedge clk_i) disable iff (rst_i || !live_q)
    carry_o |-> (cnt_q == '0));
  // R3: a borrow leaves the count at the active modulus
  a_r3_borrow_full: assert property (@(posedge clk_i) disable iff (rst_i || !live_q)
    borrow_o |-> (cnt_q == k_q));
  // R7: the modulus changes only alongside a wrap
  a_r7_k_at_wrap: assert property (@(posedge clk_i) disable iff (rst_i || !live_q)
    !$stable(k_q) |-> (carry_o || borrow_o));
  // R8: count bounded by modulus
  a_r8_bound: assert property (@(posedge clk_i) disable iff (rst_i || !live_q)
    cnt_q <= k_q);
endmodule

// File: tb/kmod_loop_counter_tb_top.sv
`timescale 1ns/1ps
module kmod_loop_counter_tb_top;
  logic       clk = 1'b0;
  logic       rst, en, dir;
  logic [3:0] ksel;
  logic       carry, borrow;

  always #2 clk = ~clk;

  kmod_loop_counter dut_i (
    .clk_i(clk), .rst_i(rst), .en_i(en), .dir_i(dir), .ksel_i(ksel),
    .carry_o(carry), .borrow_o(borrow)
  );

  int    n_chk = 0, n_fail = 0;
  bit    started = 0, done = 0;
  string tag = "R1";
  logic [15:0] m_cnt, m_k;
  bit    exp_c = 0, exp_b = 0;

  function automatic logic [15:0] k_of(input logic [3:0] s);
    int e = int'(s) + 3;
    if (e > 15) e = 15;
    return 16'(1) << e;
  endfunction

  task automatic chk(input logic got, input logic expv, input string req, input string what);
    n_chk++;
    if (got !== expv) begin
      n_fail++;
      $display("FAIL %s %s got %0b expected %0b at %0t", req, what, got, expv, $time);
    end
  endtask

  task automatic model(input bit r, input bit e, input bit d, input logic [3:0] s);
    exp_c = 0; exp_b = 0;
    if (r) begin
      m_k = k_of(s); m_cnt = m_k >> 1;
    end else if (e) begin
      if (!d) begin
        if (m_cnt == m_k) begin m_cnt = 0; m_k = k_of(s); exp_c = 1; end
        else m_cnt = m_cnt + 16'd1;
      end else begin
        if (m_cnt == 0) begin m_k = k_of(s); m_cnt = m_k; exp_b = 1; end
        else m_cnt = m_cnt - 16'd1;
      end
    end
  endtask

  task automatic cyc(input bit r, input bit e, input bit d, input logic [3:0] s);
    @(negedge clk);
    if (started) begin
      chk(carry, exp_c, (tag == "R3") ? tag : ((tag == "R1") ? "R2" : tag), "carry");
      chk(borrow, exp_b, (tag == "R2") ? "R3" : tag, "borrow");
      if (carry && borrow) chk(1'b1, 1'b0, "R6", "both pulses");
    end
    rst = r; en = e; dir = d; ksel = s;
    model(r, e, d, s);
    started = 1;
  endtask

  task automatic after_edge(input logic got_sig_is_carry, input logic expv, input string req);
    @(posedge clk); #1;
    chk(got_sig_is_carry ? carry : borrow, expv, req, got_sig_is_carry ? "carry timing" : "borrow timing");
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    bit d_r;
    void'($urandom(32'd20240917));
    rst = 1; en = 0; dir = 0; ksel = 0;
    // R1: reset state and centered start
    tag = "R1";
    cyc(1, 0, 0, 0); cyc(1, 0, 0, 0);
    @(posedge clk); #1;
    chk(carry, 1'b0, "R1", "carry in reset");
    chk(borrow, 1'b0, "R1", "borrow in reset");
    repeat (4) cyc(0, 1, 0, 0);
    after_edge(1, 1'b0, "R1");
    cyc(0, 1, 0, 0);
    after_edge(1, 1'b1, "R1");
    // R7: select change mid-count waits for the wrap
    tag = "R7";
    repeat (8) cyc(0, 1, 0, 1);
    after_edge(1, 1'b0, "R7");
    cyc(0, 1, 0, 1);
    after_edge(1, 1'b1, "R7");
    repeat (16) cyc(0, 1, 0, 1);
    after_edge(1, 1'b0, "R7");
    cyc(0, 1, 0, 1);
    after_edge(1, 1'b1, "R7");
    // R3: downward from zero borrows and reloads K
    tag = "R3";
    cyc(0, 1, 1, 0);
    after_edge(0, 1'b1, "R3");
    // R8: count at K after reload, one up edge carries
    tag = "R8";
    cyc(0, 1, 0, 0);
    after_edge(1, 1'b1, "R8");
    // R5: hold with enable low, no pulses
    tag = "R5";
    repeat (40) cyc(0, 0, 0, 0);
    repeat (40) cyc(0, 0, 1, 0);
    // R9 / R2 / R3: random reversals, gaps and select changes
    tag = "R9";
    d_r = 0;
    for (int i = 0; i < 4000; i++) begin
      logic [3:0] s;
      if ($urandom % 40 == 0) d_r = ~d_r;
      s = ($urandom % 50 == 0) ? 4'($urandom % 3) : ksel;
      cyc(0, ($urandom % 8) != 0, d_r, s);
    end
    tag = "R2";
    repeat (200) cyc(0, 1, 0, 0);
    tag = "R3";
    repeat (200) cyc(0, 1, 1, 2);
    // R4: clamped top code
    tag = "R4";
    cyc(1, 0, 0, 15);
    repeat (16384) cyc(0, 1, 0, 15);
    after_edge(1, 1'b0, "R4");
    cyc(0, 1, 0, 15);
    after_edge(1, 1'b1, "R4");
    tag = "R6";
    repeat (20) cyc(0, 1, 0, 15);
    cyc(0, 0, 0, 15);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule